// File: doc/BRIEF.md
# Interrupt Shadow Gate

This block sits beside the instruction sequencer of a small x86-style core. It decides, at each instruction boundary, whether a pending interrupt or exception may be taken there or has to wait. At every boundary the sequencer raises a one-cycle completion strobe. With the strobe it presents the opcode class of the instruction that just finished and a flag that marks that instruction as a prefix byte. Two request lines with their vectors come from outside: a maskable interrupt request and an exception request.

Some instructions put a shadow over the boundary that follows them. These are the flag-image pop, the interrupt-flag clear and set, and any load of a segment register by pop or by move. Any prefix byte also casts a shadow. At a shadowed boundary no request is accepted, and the request stays pending until the first boundary that is not shadowed. This keeps an SS load and the SP load after it together, and it keeps every prefix byte attached to its instruction. A controller state machine records what the last boundary left behind. Its states are `ST_OPEN` (no shadow), `ST_SHADOW` (the last instruction was a shadowing opcode), `ST_PREFIX` (inside a prefix chain) and `ST_ACCEPT` (a request is being handed over in this cycle).

The transitions are taken only on a completion strobe, apart from one. A prefix goes to `ST_PREFIX`. A shadowing class goes to `ST_SHADOW`. Any other instruction goes to `ST_ACCEPT` when a request is present and to `ST_OPEN` when none is. Without a strobe, `ST_ACCEPT` falls back to `ST_OPEN` after one cycle and every other state holds. When the state is `ST_ACCEPT`, the take strobe is high and the vector of the winning request, latched at the boundary, is on the output.

Top module: `int_shadow_gate`

## Requirements
- R1: While reset is active and in the first cycle after it, `take_int` is 0 and `take_exc` is 0.
- R2: A non-prefix boundary with `op_class` 1 (flag-image pop), 2 (interrupt-flag clear) or 3 (interrupt-flag set) takes no request. A request held pending through it is taken at the next unshadowed boundary. Back-to-back shadowing instructions each defer acceptance by exactly one boundary.
- R3: A non-prefix boundary with `op_class` 4 (segment register pop) or 5 (segment register load by move) takes no request. The following load, for example of SP, completes before the request is taken.
- R4: A boundary with `is_prefix` = 1 takes no request, whatever `op_class` is. A chain of prefixes keeps requests blocked until the final non-prefix instruction completes, and that instruction's own class then decides.
- R5: A non-prefix boundary with a non-shadowing class and a pending request raises `take_int` in the cycle after the completion strobe, for exactly one cycle.
- R6: `take_int` is never high unless `instr_done` was high in the previous cycle.
- R7: When both requests are pending at an accepting boundary, the exception wins. `take_exc` is 1 and `take_vec` equals `exc_vec` as sampled at the strobe. Exceptions are deferred by shadows exactly as interrupts are.
- R8: When only the interrupt request is pending at an accepting boundary, `take_exc` is 0 and `take_vec` equals `irq_vec` as sampled at the strobe.
- R9: `op_class` 0, 6 and 7 do not shadow, and neither does a boundary with no request pending, which produces no take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | One-cycle instruction completion strobe |
| op_class | input | 3 | Class of the completed instruction (0 plain, 1 flag pop, 2 flag clear, 3 flag set, 4 segment pop, 5 segment move, 6/7 plain) |
| is_prefix | input | 1 | Completed item was a prefix byte |
| irq_req | input | 1 | Maskable interrupt pending (level) |
| irq_vec | input | 8 | Interrupt vector |
| exc_req | input | 1 | Exception pending (level) |
| exc_vec | input | 8 | Exception vector |
| take_int | output | 1 | Request accepted strobe |
| take_vec | output | 8 | Vector of the accepted request |
| take_exc | output | 1 | Accepted request was the exception |

## Verification
The assertions take it for granted that a requester drops its request line in the cycle `take_int` rises for it. A request still high at the next boundary is otherwise legitimately taken again. They also take it for granted that `op_class`, `is_prefix` and the vectors are valid whenever `instr_done` is high. The stimulus raises the completion strobe for a single cycle and never in an accept cycle. It clears only the request that was taken, in that accept cycle, and leaves the other request pending on purpose so that the priority and the deferral can be watched.

// File: rtl/int_shadow_pkg.sv
package int_shadow_pkg;
    localparam int CLS_W = 3;
    localparam int VEC_W = 8;

    typedef enum logic [CLS_W-1:0] {
        CLS_PLAIN    = 3'd0,
        CLS_FLAG_POP = 3'd1,
        CLS_FLAG_CLR = 3'd2,
        CLS_FLAG_SET = 3'd3,
        CLS_SEG_POP  = 3'd4,
        CLS_SEG_MOV  = 3'd5,
        CLS_OTHER_A  = 3'd6,
        CLS_OTHER_B  = 3'd7
    } op_class_e;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_SHADOW = 2'd1,
        ST_PREFIX = 2'd2,
        ST_ACCEPT = 2'd3
    } gate_state_e;
endpackage

// File: rtl/shadow_classify.sv
module shadow_classify
    import int_shadow_pkg::*;
#(
    parameter int CW = CLS_W
) (
    input  logic [CW-1:0] cls,
    input  logic          pfx,
    output logic          casts_shadow,
    output logic          holds_prefix
);
    op_class_e cls_e;

    always_comb begin
        cls_e        = op_class_e'(cls);
        holds_prefix = pfx;
        casts_shadow = 1'b0;
        if (!pfx) begin
            unique case (cls_e)
                CLS_FLAG_POP, CLS_FLAG_CLR, CLS_FLAG_SET: casts_shadow = 1'b1;
                CLS_SEG_POP, CLS_SEG_MOV:                 casts_shadow = 1'b1;
                default:                                  casts_shadow = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/shadow_req_arb.sv
module shadow_req_arb #(
    parameter int VW = 8
) (
    input  logic          irq_req,
    input  logic [VW-1:0] irq_vec,
    input  logic          exc_req,
    input  logic [VW-1:0] exc_vec,
    output logic          any_req,
    output logic          win_exc,
    output logic [VW-1:0] win_vec
);
    always_comb begin
        any_req = irq_req | exc_req;
        win_exc = exc_req;
        win_vec = exc_req ? exc_vec : irq_vec;
    end
endmodule

// File: rtl/int_shadow_gate.sv
module int_shadow_gate
    import int_shadow_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int CW = CLS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_done,
    input  logic [CW-1:0] op_class,
    input  logic          is_prefix,
    input  logic          irq_req,
    input  logic [VW-1:0] irq_vec,
    input  logic          exc_req,
    input  logic [VW-1:0] exc_vec,
    output logic          take_int,
    output logic [VW-1:0] take_vec,
    output logic          take_exc
);
    gate_state_e   state_q, state_d;
    logic          casts_shadow, holds_prefix;
    logic          any_req, win_exc;
    logic [VW-1:0] win_vec;
    logic [VW-1:0] vec_q;
    logic          exc_q;

    shadow_classify #(.CW(CW)) u_cls (
        .cls          (op_class),
        .pfx          (is_prefix),
        .casts_shadow (casts_shadow),
        .holds_prefix (holds_prefix)
    );

    shadow_req_arb #(.VW(VW)) u_arb (
        .irq_req (irq_req),
        .irq_vec (irq_vec),
        .exc_req (exc_req),
        .exc_vec (exc_vec),
        .any_req (any_req),
        .win_exc (win_exc),
        .win_vec (win_vec)
    );

    // next-state: only a completion strobe moves the shadow
    always_comb begin
        state_d = state_q;
        if (instr_done) begin
            if (holds_prefix)      state_d = ST_PREFIX;
            else if (casts_shadow) state_d = ST_SHADOW;
            else if (any_req)      state_d = ST_ACCEPT;
            else                   state_d = ST_OPEN;
        end else begin
            unique case (state_q)
                ST_ACCEPT: state_d = ST_OPEN;
                ST_OPEN, ST_SHADOW, ST_PREFIX: state_d = state_q;
                default:   state_d = ST_OPEN;
            endcase
        end
    end

    // state register and handoff capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            vec_q   <= '0;
            exc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (instr_done && state_d == ST_ACCEPT) begin
                vec_q <= win_vec;
                exc_q <= win_exc;
            end
        end
    end

    // outputs
    always_comb begin
        take_int = 1'b0;
        take_exc = 1'b0;
        take_vec = vec_q;
        unique case (state_q)
            ST_ACCEPT: begin
                take_int = 1'b1;
                take_exc = exc_q;
            end
            default: begin
                take_int = 1'b0;
                take_exc = 1'b0;
            end
        endcase
    end

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !take_int && !take_exc);

    p_flag_shadow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && !is_prefix && (op_class == 3'd1 || op_class == 3'd2 || op_class == 3'd3))
        |=> !take_int);

    p_seg_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && !is_prefix && (op_class == 3'd4 || op_class == 3'd5)) |=> !take_int);

    p_prefix_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && is_prefix) |=> !take_int);

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> !take_int);

    p_only_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |-> $past(instr_done));

    p_exc_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && !is_prefix && op_class == 3'd0 && exc_req)
        |=> take_int && take_exc && take_vec == $past(exc_vec));

    p_irq_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && !is_prefix && op_class == 3'd0 && irq_req && !exc_req)
        |=> take_int && !take_exc && take_vec == $past(irq_vec));
endmodule

// File: tb/int_shadow_gate_tb_top.sv
module int_shadow_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_done = 1'b0;
    logic [2:0] op_class = 3'd0;
    logic       is_prefix = 1'b0;
    logic       irq_req = 1'b0;
    logic [7:0] irq_vec = 8'h00;
    logic       exc_req = 1'b0;
    logic [7:0] exc_vec = 8'h00;
    logic       take_int;
    logic [7:0] take_vec;
    logic       take_exc;

    typedef struct {
        bit         tk;
        logic [7:0] vec;
        bit         exc;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done_seen = 1'b0;
    bit   finished  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_shadow_gate dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .op_class   (op_class),
        .is_prefix  (is_prefix),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec),
        .exc_req    (exc_req),
        .exc_vec    (exc_vec),
        .take_int   (take_int),
        .take_vec   (take_vec),
        .take_exc   (take_exc)
    );

    always @(posedge clk) done_seen <= instr_done;

    // monitor: one expected item per completion strobe
    always @(negedge clk) begin
        if (rst_n && done_seen && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (take_int !== e.tk) begin
                n_fail++;
                $display("FAIL %s: take_int=%0b expected %0b", e.tag, take_int, e.tk);
            end else if (e.tk && (take_vec !== e.vec || take_exc !== e.exc)) begin
                n_fail++;
                $display("FAIL %s: vec=%h exc=%0b expected vec=%h exc=%0b",
                         e.tag, take_vec, take_exc, e.vec, e.exc);
            end
        end else if (rst_n && !done_seen) begin
            n_checks++;
            if (take_int !== 1'b0) begin
                n_fail++;
                $display("FAIL R6: take_int=%0b expected 0 without a boundary", take_int);
            end
        end
    end

    // driver: one boundary, expected outcome from the requirements
    task automatic boundary(input logic [2:0] cls, input bit pfx, input string tag);
        exp_t e;
        bit   shadow;
        shadow = pfx || (cls >= 3'd1 && cls <= 3'd5);
        e.tk  = !shadow && (irq_req || exc_req);
        e.exc = exc_req;
        e.vec = exc_req ? exc_vec : irq_vec;
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        op_class   = cls;
        is_prefix  = pfx;
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        if (e.tk) begin
            if (e.exc) exc_req = 1'b0;
            else       irq_req = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (take_int !== 1'b0 || take_exc !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: take=%0b exc=%0b expected 0 0 in reset", take_int, take_exc);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (take_int !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: take=%0b expected 0 after reset", take_int);
        end

        // R9: no request, no take
        boundary(3'd0, 1'b0, "R9 idle");

        // R5/R8: plain accept
        irq_vec = 8'h21; irq_req = 1'b1;
        boundary(3'd0, 1'b0, "R5 R8 plain accept");

        // R6: pending request, no boundary for a while
        irq_vec = 8'h22; irq_req = 1'b1;
        repeat (4) @(negedge clk);
        boundary(3'd0, 1'b0, "R6 taken only at boundary");

        // R2: each flag class shadows one boundary
        irq_vec = 8'h30; irq_req = 1'b1;
        boundary(3'd1, 1'b0, "R2 flag pop shadow");
        boundary(3'd0, 1'b0, "R2 taken after flag pop");
        irq_vec = 8'h31; irq_req = 1'b1;
        boundary(3'd2, 1'b0, "R2 flag clear shadow");
        boundary(3'd0, 1'b0, "R2 taken after flag clear");
        irq_vec = 8'h32; irq_req = 1'b1;
        boundary(3'd3, 1'b0, "R2 flag set shadow");
        boundary(3'd3, 1'b0, "R2 back-to-back shadow");
        boundary(3'd2, 1'b0, "R2 third shadow");
        boundary(3'd0, 1'b0, "R2 taken after chain");

        // R3: SS load then SP load stay together
        irq_vec = 8'h40; irq_req = 1'b1;
        boundary(3'd4, 1'b0, "R3 segment pop shadow");
        boundary(3'd0, 1'b0, "R3 taken after SP load");
        irq_vec = 8'h41; irq_req = 1'b1;
        boundary(3'd5, 1'b0, "R3 segment move shadow");
        boundary(3'd0, 1'b0, "R3 taken after SP move");

        // R4: prefix chain, class ignored while prefix
        irq_vec = 8'h50; irq_req = 1'b1;
        boundary(3'd0, 1'b1, "R4 prefix 1");
        boundary(3'd7, 1'b1, "R4 prefix 2");
        boundary(3'd6, 1'b1, "R4 prefix 3");
        boundary(3'd0, 1'b0, "R4 taken after prefixed op");
        irq_vec = 8'h51; irq_req = 1'b1;
        boundary(3'd0, 1'b1, "R4 prefix before shadow op");
        boundary(3'd5, 1'b0, "R4 prefixed segment move shadows");
        boundary(3'd0, 1'b0, "R4 taken after shadow");

        // R7: exception priority, irq left pending
        irq_vec = 8'h60; irq_req = 1'b1;
        exc_vec = 8'h0D; exc_req = 1'b1;
        boundary(3'd0, 1'b0, "R7 exception wins");
        boundary(3'd0, 1'b0, "R8 irq after exception");

        // R7: exception deferred by shadow
        exc_vec = 8'h06; exc_req = 1'b1;
        boundary(3'd2, 1'b0, "R7 exception shadowed");
        boundary(3'd0, 1'b1, "R7 exception blocked by prefix");
        boundary(3'd0, 1'b0, "R7 exception taken");

        // R9: classes 6 and 7 do not shadow
        irq_vec = 8'h70; irq_req = 1'b1;
        boundary(3'd6, 1'b0, "R9 class 6 open");
        irq_vec = 8'h71; irq_req = 1'b1;
        boundary(3'd7, 1'b0, "R9 class 7 open");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule